// File: doc/BRIEF.md
# Fractional-Order Multi-Scroll Chaos Generator

This block advances a three-state fractional-order chaotic system by one step on every clock where the step enable is high. The states x, y and z are signed fixed-point words with 16 integer and 24 fraction bits. Each state update is a driving term scaled by the step size raised to that state's order, minus a weighted sum over a short window of that state's own history. The weights are binomial coefficients of the fractional order.

The y equation contains a staircase nonlinearity of z. It is built from one comparator per threshold, an encoder that reduces the comparator outputs to a one-hot level select, and a level multiplexer. The number and height of the stairs set how many scrolls the V-shaped or heart-shaped attractor shows. When the asymmetric mode is selected, a second staircase is used whenever x is not strictly positive. This gives a different scroll layout on each side.

Thresholds, levels and the initial state are sampled while reset is held. After reset, the block runs freely under the step enable. The outputs are registered state words with no handshake: each new value is valid from the clock edge that made it and stays until the next enabled step. Step sizes, orders, the window length and the z gains are elaboration parameters, and power-of-two gains are realised as shifts.

Top module: `vsc_multiscroll_gen`

## Requirements
- R1: While `rst` is high, each state register takes its `init_*` value, and every older history entry of the window is cleared to zero.
- R2: When `step_en` is low outside reset, `x_out`, `y_out` and `z_out` keep their values.
- R3: An enabled step sets x to ((y − x) >>> HSH1) − S_x. Here S_x is the sum over taps j = 1..L of bits [63:24] of the signed product w_j(Q1) × (the state j−1 steps old), with tap 1 being the current state.
- R4: An enabled step sets y to (±B >>> HSH2) − S_y, where B = 1.0 − (z <<< MSH) + G. The sign is negative only when bit 39 of x is set, so x = 0 counts as positive.
- R5: An enabled step sets z to ((|x| − (z >>> RSH)) >>> HSH3) − S_z, where |x| is the two's-complement magnitude of x.
- R6: The weights are integers in units of 2^-24. They are computed as w_0 = 2^24 and w_j = w_{j−1} − trunc(trunc((Q+256)·w_{j−1}/256)/j), where Q is the order times 256 and trunc rounds toward zero.
- R7: With ascending thresholds t[0] < … < t[NTH−1], G is zero when z < t[0]. Otherwise G is level[k], where k is the highest index with z ≥ t[k]. A z exactly equal to a threshold therefore takes the level above it.
- R8: With `asym_mode` low, the positive bank is always used. With `asym_mode` high, the positive bank is used when x > 0 and the negative bank when x ≤ 0.
- R9: Threshold and level inputs are sampled only while `rst` is high. Later changes to them do not affect the state sequence.
- R10: All state arithmetic is 40-bit two's complement with 24 fraction bits and wraps on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads initial state and staircase settings |
| step_en | input | 1 | Advance the system by one step on this edge |
| asym_mode | input | 1 | 0: one staircase; 1: bank chosen by the sign of x |
| thr_pos | input | NTH×40 | Ascending thresholds of the positive bank, Q16.24 |
| lvl_pos | input | NTH×40 | Levels of the positive bank, Q16.24 |
| thr_neg | input | NTH×40 | Ascending thresholds of the negative bank, Q16.24 |
| lvl_neg | input | NTH×40 | Levels of the negative bank, Q16.24 |
| init_x | input | 40 | Initial x, Q16.24 |
| init_y | input | 40 | Initial y, Q16.24 |
| init_z | input | 40 | Initial z, Q16.24 |
| x_out | output | 40 | Current x state |
| y_out | output | 40 | Current y state |
| z_out | output | 40 | Current z state |

## Verification
The in-line properties check four things on every clock:
- state is held when no step is requested;
- reset loads the initial words;
- the captured staircase settings stay frozen after reset;
- the encoder yields at most one level select, and G is zero for any z below the lowest threshold.

The exact arithmetic cannot be seen cycle by cycle from the properties alone. This covers the step equations, the binomial weights, the window sum and the level chosen one LSB below, at and above each threshold in both banks and both modes. The bench's directed scenarios show it by comparing every output word against an independent fixed-point model.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int SW   = 40;  // state word width
  localparam int FRAC = 24;  // fraction bits
  localparam int CW   = 32;  // weight word width

  typedef logic signed [SW-1:0] fix_t;

  // binomial weight of tap j for order q256/256, in units of 2^-FRAC
  function automatic longint gl_weight(input int q256, input int j);
    longint w;
    w = longint'(1) <<< FRAC;
    for (int k = 1; k <= j; k++) begin
      w = w - ((longint'(q256 + 256) * w) / 256) / k;
    end
    return w;
  endfunction
endpackage

// File: rtl/vsc_fracmem.sv
module vsc_fracmem
  import vsc_pkg::*;
#(
  parameter int L = 8,
  parameter int Q = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  fix_t init_val,
  input  fix_t next_val,
  output fix_t cur,
  output fix_t msum
);
  localparam int PW = SW + CW;

  fix_t hist [L];
  fix_t term [L];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist[0] <= init_val;
      for (int i = 1; i < L; i++) hist[i] <= '0;
    end else if (adv) begin
      hist[0] <= next_val;
      for (int i = 1; i < L; i++) hist[i] <= hist[i-1];
    end
  end

  // one weighted tap per history entry; tap j uses weight index j+1
  for (genvar j = 0; j < L; j++) begin : g_tap
    localparam logic signed [CW-1:0] WJ = CW'(gl_weight(Q, j + 1));
    logic signed [PW-1:0] prod;
    logic unused_tap;
    assign prod       = hist[j] * WJ;
    assign term[j]    = prod[FRAC+SW-1:FRAC];
    assign unused_tap = ^{prod[PW-1:FRAC+SW], prod[FRAC-1:0]};
  end

  always_comb begin
    msum = '0;
    for (int j = 0; j < L; j++) msum = msum + term[j];
  end

  assign cur = hist[0];

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cur));

  p_reset_load_r1: assert property (@(posedge clk)
    rst |=> cur == $past(init_val));
endmodule

// File: rtl/vsc_stair.sv
module vsc_stair
  import vsc_pkg::*;
#(
  parameter int NTH = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  fix_t                    z,
  input  logic [NTH-1:0][SW-1:0]  thr,
  input  logic [NTH-1:0][SW-1:0]  lvl,
  output fix_t                    g
);
  logic [NTH-1:0] above;
  logic [NTH-1:0] sel;

  // comparator bank and thermometer-to-one-hot encoder
  for (genvar i = 0; i < NTH; i++) begin : g_cmp
    assign above[i] = (z >= $signed(thr[i]));
    if (i == NTH - 1) begin : g_top
      assign sel[i] = above[i];
    end else begin : g_mid
      assign sel[i] = above[i] & ~above[i+1];
    end
  end

  // level multiplexer
  always_comb begin
    g = '0;
    for (int i = 0; i < NTH; i++) begin
      if (sel[i]) g = g | fix_t'(lvl[i]);
    end
  end

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  p_zero_below_r7: assert property (@(posedge clk) disable iff (rst)
    (z < $signed(thr[0])) |-> (g == '0));
endmodule

// File: rtl/vsc_multiscroll_gen.sv
module vsc_multiscroll_gen
  import vsc_pkg::*;
#(
  parameter int L    = 8,
  parameter int NTH  = 5,
  parameter int Q1   = 320,
  parameter int Q2   = 256,
  parameter int Q3   = 320,
  parameter int HSH1 = 5,
  parameter int HSH2 = 4,
  parameter int HSH3 = 5,
  parameter int MSH  = 0,
  parameter int RSH  = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_en,
  input  logic                   asym_mode,
  input  logic [NTH-1:0][39:0]   thr_pos,
  input  logic [NTH-1:0][39:0]   lvl_pos,
  input  logic [NTH-1:0][39:0]   thr_neg,
  input  logic [NTH-1:0][39:0]   lvl_neg,
  input  logic [39:0]            init_x,
  input  logic [39:0]            init_y,
  input  logic [39:0]            init_z,
  output logic [39:0]            x_out,
  output logic [39:0]            y_out,
  output logic [39:0]            z_out
);
  localparam fix_t ONE = fix_t'(longint'(1) <<< FRAC);

  logic [NTH-1:0][SW-1:0] thr_p_q, lvl_p_q, thr_n_q, lvl_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_p_q <= thr_pos;
      lvl_p_q <= lvl_pos;
      thr_n_q <= thr_neg;
      lvl_n_q <= lvl_neg;
    end
  end

  fix_t x_c, y_c, z_c;
  fix_t sx, sy, sz;
  fix_t nx, ny, nz;

  vsc_fracmem #(.L(L), .Q(Q1)) u_mem_x (
    .clk(clk), .rst(rst), .adv(step_en), .init_val(fix_t'(init_x)),
    .next_val(nx), .cur(x_c), .msum(sx));
  vsc_fracmem #(.L(L), .Q(Q2)) u_mem_y (
    .clk(clk), .rst(rst), .adv(step_en), .init_val(fix_t'(init_y)),
    .next_val(ny), .cur(y_c), .msum(sy));
  vsc_fracmem #(.L(L), .Q(Q3)) u_mem_z (
    .clk(clk), .rst(rst), .adv(step_en), .init_val(fix_t'(init_z)),
    .next_val(nz), .cur(z_c), .msum(sz));

  // staircase banks and sign-of-x bank choice
  fix_t g_p, g_n, g_sel;
  logic x_neg, x_pos, use_neg;

  vsc_stair #(.NTH(NTH)) u_stair_pos (
    .clk(clk), .rst(rst), .z(z_c), .thr(thr_p_q), .lvl(lvl_p_q), .g(g_p));
  vsc_stair #(.NTH(NTH)) u_stair_neg (
    .clk(clk), .rst(rst), .z(z_c), .thr(thr_n_q), .lvl(lvl_n_q), .g(g_n));

  assign x_neg   = x_c[SW-1];
  assign x_pos   = ~x_neg & (x_c != '0);
  assign use_neg = asym_mode & ~x_pos;
  assign g_sel   = use_neg ? g_n : g_p;

  // x path
  fix_t d_xy, fx;
  assign d_xy = y_c - x_c;
  assign fx   = d_xy >>> HSH1;
  assign nx   = fx - sx;

  // y path: G plus inverted shifted z plus one, then sign-controlled negate
  fix_t zm, brk, ybr, fy;
  assign zm  = z_c <<< MSH;
  assign brk = g_sel + ~zm + ONE + fix_t'(1);
  assign ybr = x_neg ? (~brk + fix_t'(1)) : brk;
  assign fy  = ybr >>> HSH2;
  assign ny  = fy - sy;

  // z path: magnitude of x minus scaled z
  fix_t ax, zr, d_z, fz;
  assign ax  = x_neg ? (~x_c + fix_t'(1)) : x_c;
  assign zr  = z_c >>> RSH;
  assign d_z = ax - zr;
  assign fz  = d_z >>> HSH3;
  assign nz  = fz - sz;

  assign x_out = x_c;
  assign y_out = y_c;
  assign z_out = z_c;

  p_params_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(thr_p_q) && $stable(lvl_p_q) &&
                     $stable(thr_n_q) && $stable(lvl_n_q)));
endmodule

// File: tb/vsc_multiscroll_gen_tb.sv
`timescale 1ns/1ps
module vsc_multiscroll_gen_tb;
  localparam int LW = 8, NT = 5;
  localparam int Q1 = 320, Q2 = 256, Q3 = 320;
  localparam int SH1 = 5, SH2 = 4, SH3 = 5, MS = 0, RS = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic asym_mode = 1'b0;
  logic [NT-1:0][39:0] thr_pos, lvl_pos, thr_neg, lvl_neg;
  logic [39:0] init_x = '0, init_y = '0, init_z = '0;
  logic [39:0] x_out, y_out, z_out;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  vsc_multiscroll_gen #(.L(LW), .NTH(NT), .Q1(Q1), .Q2(Q2), .Q3(Q3),
    .HSH1(SH1), .HSH2(SH2), .HSH3(SH3), .MSH(MS), .RSH(RS)) u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .asym_mode(asym_mode),
    .thr_pos(thr_pos), .lvl_pos(lvl_pos), .thr_neg(thr_neg), .lvl_neg(lvl_neg),
    .init_x(init_x), .init_y(init_y), .init_z(init_z),
    .x_out(x_out), .y_out(y_out), .z_out(z_out));

  // ---------------- reference model ----------------
  logic signed [39:0] mx [LW], my [LW], mz [LW];
  logic signed [31:0] w1 [LW], w2 [LW], w3 [LW];
  logic [NT-1:0][39:0] m_tp, m_lp, m_tn, m_ln;

  function automatic logic signed [39:0] rf(input real r);
    return 40'(longint'(r * 16777216.0));
  endfunction

  function automatic longint bw(input int q, input int j);
    longint v, t;
    v = 64'sd16777216;
    for (int k = 1; k <= j; k++) begin
      t = (longint'(q + 256) * v) / 256;
      v = v - t / k;
    end
    return v;
  endfunction

  function automatic logic signed [39:0] m_stair(input logic signed [39:0] z, input logic neg);
    int cnt = 0;
    for (int i = 0; i < NT; i++) begin
      if (neg ? (z >= $signed(m_tn[i])) : (z >= $signed(m_tp[i]))) cnt++;
    end
    if (cnt == 0) return '0;
    return neg ? $signed(m_ln[cnt-1]) : $signed(m_lp[cnt-1]);
  endfunction

  task automatic m_step();
    logic signed [39:0] x, y, z, d, g, brk, yb, ax, fx, fy, fz, sx, sy, sz;
    logic signed [71:0] p;
    x = mx[0]; y = my[0]; z = mz[0];
    d = y - x; fx = d >>> SH1;
    g = m_stair(z, asym_mode && !(x > 40'sd0));
    brk = rf(1.0) - (z <<< MS) + g;
    yb = x[39] ? -brk : brk; fy = yb >>> SH2;
    ax = x[39] ? -x : x; d = ax - (z >>> RS); fz = d >>> SH3;
    sx = '0; sy = '0; sz = '0;
    for (int j = 0; j < LW; j++) begin
      p = mx[j] * w1[j]; sx = sx + p[63:24];
      p = my[j] * w2[j]; sy = sy + p[63:24];
      p = mz[j] * w3[j]; sz = sz + p[63:24];
    end
    for (int j = LW - 1; j > 0; j--) begin
      mx[j] = mx[j-1]; my[j] = my[j-1]; mz[j] = mz[j-1];
    end
    mx[0] = fx - sx; my[0] = fy - sy; mz[0] = fz - sz;
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " x"}, x_out, mx[0]);
    chk({req, " y"}, y_out, my[0]);
    chk({req, " z"}, z_out, mz[0]);
  endtask

  task automatic set_banks();
    for (int i = 0; i < NT; i++) begin
      thr_pos[i] = rf(1.56 + 1.15 * i);
      lvl_pos[i] = rf(1.15 * (i + 1));
      thr_neg[i] = rf(0.9 + 1.1 * i);
      lvl_neg[i] = rf(2.0 * (i + 1));
    end
  endtask

  task automatic do_reset(input logic [39:0] xi, input logic [39:0] yi, input logic [39:0] zi);
    @(negedge clk);
    rst = 1'b1; step_en = 1'b0;
    init_x = xi; init_y = yi; init_z = zi;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_tp = thr_pos; m_lp = lvl_pos; m_tn = thr_neg; m_ln = lvl_neg;
    for (int j = 0; j < LW; j++) begin mx[j] = '0; my[j] = '0; mz[j] = '0; end
    mx[0] = xi; my[0] = yi; mz[0] = zi;
  endtask

  task automatic one_step(input string req);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    m_step();
    chk_all(req);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    set_banks();
    asym_mode = 1'b0;
    do_reset(rf(0.5), rf(-0.25), rf(1.6));
    chk("R1 reset x", x_out, rf(0.5));
    chk("R1 reset y", y_out, rf(-0.25));
    chk("R1 reset z", z_out, rf(1.6));
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    chk_all("R2 hold");
  endtask

  task automatic t_stair(input logic am, input real xs);
    logic signed [39:0] zt;
    for (int i = 0; i < NT; i++) begin
      for (int off = -1; off <= 1; off++) begin
        asym_mode = am;
        zt = ((am && !(rf(xs) > 40'sd0)) ? $signed(thr_neg[i]) : $signed(thr_pos[i])) + 40'(off);
        do_reset(rf(xs), rf(0.125), zt);
        one_step(am ? "R7 R8 stair asym" : "R7 R4 stair sym");
      end
    end
    do_reset(rf(xs), rf(0.125), rf(0.3));
    one_step("R7 below lowest threshold");
    do_reset(rf(xs), rf(0.125), rf(9.0));
    one_step("R7 above top threshold");
  endtask

  task automatic t_zero_x();
    asym_mode = 1'b1;
    do_reset('0, rf(0.5), rf(2.1));
    one_step("R4 R8 x equals zero");
  endtask

  task automatic t_free_run(input logic am);
    asym_mode = am;
    do_reset(rf(0.5), rf(-0.25), rf(1.6));
    for (int n = 0; n < 60; n++) begin
      step_en = (n % 4 != 3);
      @(negedge clk);
      if (step_en) m_step();
      chk_all("R3 R5 R6 R10 free run");
    end
    step_en = 1'b0;
  endtask

  task automatic t_param_ignore();
    asym_mode = 1'b1;
    do_reset(rf(-0.4), rf(0.3), rf(2.0));
    for (int i = 0; i < NT; i++) begin
      thr_pos[i] = rf(0.01 * i); lvl_pos[i] = rf(30.0);
      thr_neg[i] = rf(0.02 * i); lvl_neg[i] = rf(-30.0);
    end
    for (int n = 0; n < 12; n++) one_step("R9 params ignored");
    set_banks();
  endtask

  initial begin
    for (int j = 0; j < LW; j++) begin
      w1[j] = 32'(bw(Q1, j + 1));
      w2[j] = 32'(bw(Q2, j + 1));
      w3[j] = 32'(bw(Q3, j + 1));
    end
    t_reset();
    t_hold();
    t_stair(1'b0, 0.75);
    t_stair(1'b0, -0.75);
    t_stair(1'b1, 0.75);
    t_stair(1'b1, -0.75);
    t_zero_x();
    t_free_run(1'b0);
    t_free_run(1'b1);
    t_param_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule